// File: doc/BRIEF.md
# Retriggerable Slow-Mode Speed Governor

This block sits next to an accelerated processor and decides when the processor must leave full speed and run in lockstep with the 1 MHz system bus. It watches every CPU access. Some accesses drive timing-critical hardware: a peripheral slot's device-select window, the speaker toggle and the paddle timer trigger. When one of these is hit and its trigger is enabled, the block raises a slow flag and loads a long countdown. The clock and bus logic reads that flag and runs the CPU synchronously while it is high.

The countdown advances only on a 1 MHz reference tick. Every new qualifying access reloads it to its full value, so a peripheral that is polled continuously keeps the machine slow. Full speed returns only after the count has run out with no further trigger. The default reload is 53,000 ticks, which is about 53 ms. A global acceleration enable gives a master override: while it is low, the block holds slow mode.

Top module: `speed_governor`

## Requirements
- R1: After reset the countdown is zero and `slow` is low whenever `accel_en` is high.
- R2: An access strobe to an address 0xC080+16·n through 0xC08F+16·n (n = 1..7) sets `slow` on the cycle after the strobe only when `slot_en[n-1]` is 1. With the bit at 0 the access has no effect.
- R3: A strobe at address 0xC030 triggers slow mode only when `spkr_en` is 1.
- R4: A strobe at address 0xC070 triggers slow mode only when `pdl_en` is 1.
- R5: A cycle without `acc_stb` never triggers. Addresses outside the slot, speaker and paddle locations never trigger, whatever their low byte.
- R6: After the last trigger, `slow` stays high through exactly RELOAD-1 `tick` cycles and falls after the RELOAD-th. Cycles without `tick` do not shorten the window.
- R7: A trigger while slow mode is active reloads the countdown to its full RELOAD value.
- R8: While `accel_en` is low, `slow` is high in the same cycle, regardless of the countdown.
- R9: Ticks with no trigger while the countdown is zero leave `slow` low; the count never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz reference pulse, one clock wide |
| acc_stb | input | 1 | Valid CPU access this cycle |
| addr | input | 16 | CPU address |
| slot_en | input | 7 | Bit n-1 enables slow-down for slot n |
| spkr_en | input | 1 | Enables the speaker trigger |
| pdl_en | input | 1 | Enables the paddle trigger |
| accel_en | input | 1 | Global acceleration enable; low forces slow mode |
| slow | output | 1 | High when the CPU must run synchronously |

## Verification
The bench sweeps the whole 0xC0xx page under several enable patterns. A decoder that is off by one slot, that also accepts slot 0's window, or that ignores the enable mask makes `slow` differ from the arithmetic prediction at specific addresses. Addresses with the right low byte on the wrong page catch a decoder that never compares the upper byte. The window length is counted exactly tick by tick, including gaps without ticks. An off-by-one reload, a decrement on every clock, or a retrigger that does not reload would each drop `slow` at the wrong tick. Idle ticks at zero catch a counter that wraps to all ones and falsely goes slow.

// File: rtl/speed_governor.sv
module speed_governor #(
  parameter int unsigned RELOAD = 53000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        acc_stb,
  input  logic [15:0] addr,
  input  logic [6:0]  slot_en,
  input  logic        spkr_en,
  input  logic        pdl_en,
  input  logic        accel_en,
  output logic        slow
);
  localparam int CNT_W = $clog2(RELOAD + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt;
  logic [6:0]       slot_sel;
  logic             io_page, trig;

  assign io_page = addr[15:8] == 8'hC0;

  for (genvar n = 1; n <= 7; n++) begin : g_slot
    assign slot_sel[n-1] = io_page && addr[7:4] == 4'(8 + n);
  end

  assign trig = acc_stb &&
                (|(slot_sel & slot_en) ||
                 (spkr_en && addr == 16'hC030) ||
                 (pdl_en  && addr == 16'hC070));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (trig)            cnt <= FULL;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign slow = !accel_en || cnt != 0;
endmodule

module speed_governor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        acc_stb,
  input logic [15:0] addr,
  input logic [6:0]  slot_en,
  input logic        spkr_en,
  input logic        pdl_en,
  input logic        accel_en,
  input logic        slow
);
  logic [2:0] sn;
  logic       slot_hit;
  assign sn = addr[6:4];
  assign slot_hit = addr[15:8] == 8'hC0 && addr[7] && sn != 3'd0 && slot_en[sn - 3'd1];

  p_reset_fast_r1: assert property (@(posedge clk)
    $rose(rst_n) && accel_en |-> !slow);
  p_slot_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && slot_hit |=> slow);
  p_spkr_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && spkr_en && addr == 16'hC030 |=> slow);
  p_pdl_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && pdl_en && addr == 16'hC070 |=> slow);
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slow && accel_en && !tick |=> slow || !accel_en);
  p_fall_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow) && $past(accel_en) |-> $past(tick));
  p_force_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_en |-> slow);
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slow && !acc_stb |=> !slow || !accel_en);
endmodule

bind speed_governor speed_governor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .acc_stb(acc_stb), .addr(addr),
  .slot_en(slot_en), .spkr_en(spkr_en), .pdl_en(pdl_en),
  .accel_en(accel_en), .slow(slow));

// File: tb/speed_governor_tb.sv
module speed_governor_tb;
  localparam int RL = 6;

  logic clk = 0, rst_n = 0, tick = 0, acc_stb = 0;
  logic [15:0] addr = 16'h0000;
  logic [6:0] slot_en = 0;
  logic spkr_en = 0, pdl_en = 0, accel_en = 1;
  logic slow;
  int checks = 0, errors = 0;

  speed_governor #(.RELOAD(RL)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%b expected=%b", req, addr, act, exp);
    end
  endtask

  task automatic go(input logic s, input logic [15:0] a, input logic t);
    acc_stb = s; addr = a; tick = t;
    @(negedge clk);
    acc_stb = 0; tick = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < RL; i++) go(0, 16'h0000, 1);
  endtask

  function automatic logic hit(input logic [15:0] a, input logic [6:0] m,
                               input logic sp, input logic pd);
    int n;
    if (a[15:8] != 8'hC0) return 0;
    if (a == 16'hC030) return sp;
    if (a == 16'hC070) return pd;
    n = int'(a[7:4]) - 8;
    if (n >= 1 && n <= 7) return m[n-1];
    return 0;
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] masks [4];
    masks = '{7'h00, 7'h55, 7'h2A, 7'h7F};
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(slow, 0, "R1 reset fast");

    for (int m = 0; m < 4; m++) begin
      slot_en = masks[m]; spkr_en = m[0]; pdl_en = m[1];
      for (int a = 0; a < 256; a++) begin
        go(1, {8'hC0, 8'(a)}, 0);
        chk(slow, hit({8'hC0, 8'(a)}, slot_en, spkr_en, pdl_en),
            a == 8'h30 ? "R3 speaker" : a == 8'h70 ? "R4 paddle" : "R2 slot decode");
        drain();
      end
    end

    slot_en = 7'h7F; spkr_en = 1; pdl_en = 1;
    foreach (masks[i]) begin
      logic [15:0] bad [4];
      bad = '{16'hC190, 16'h4030, 16'hD070, 16'h00F5};
      go(1, bad[i], 0);
      chk(slow, 0, "R5 other page");
    end
    go(0, 16'hC090, 0);
    chk(slow, 0, "R5 no strobe");
    go(0, 16'hC030, 0);
    chk(slow, 0, "R5 no strobe");

    go(1, 16'hC0E4, 0);
    for (int i = 0; i < RL - 1; i++) begin
      go(0, 16'h0000, 1);
      go(0, 16'h0000, 0);
      go(0, 16'h0000, 0);
      chk(slow, 1, "R6 window hold");
    end
    go(0, 16'h0000, 1);
    chk(slow, 0, "R6 window end");

    go(1, 16'hC0A0, 0);
    for (int i = 0; i < 4; i++) go(0, 16'h0000, 1);
    go(1, 16'hC070, 1);
    for (int i = 0; i < RL - 1; i++) go(0, 16'h0000, 1);
    chk(slow, 1, "R7 reload full");
    go(0, 16'h0000, 1);
    chk(slow, 0, "R7 reload end");

    accel_en = 0;
    #1 chk(slow, 1, "R8 forced slow");
    @(negedge clk);
    for (int i = 0; i < 3; i++) go(0, 16'h0000, 1);
    chk(slow, 1, "R8 forced slow hold");
    accel_en = 1;
    #1 chk(slow, 0, "R8 release");
    @(negedge clk);

    for (int i = 0; i < 20; i++) go(0, 16'h0000, 1);
    chk(slow, 0, "R9 no wrap");
    go(1, 16'hC0F0, 0);
    chk(slow, 1, "R9 trigger after idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule